// File: doc/BRIEF.md
# Condition Register Field Transfer Unit

This unit holds a 32-bit condition register split into eight 4-bit fields. It performs field-level moves between that register, a 64-bit general register operand and four fixed-point exception flags. A request carries an operation code, an 8-bit field mask, a 3-bit field index, the 64-bit operand and the flags. One clock edge later the unit presents a result word and the updated register.

Fields and mask bits use big-endian numbering. Field 0 is the most significant nibble of the register, and it is also the most significant bit of the mask. In the 64-bit operand and result, field n sits at big-endian bit positions 4n+32 to 4n+35, where bit 0 is the most significant. The upper 32 operand bits are never used.

Operation codes on `req_op`: 0 idle, 1 write the first selected field, 2 write every selected field, 3 read the first selected field, 4 pack the flags into one field, 5 read the whole register. Codes 6 and 7 are undefined.

Top module: `cr_field_xfer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `cr_out`, `rsp_valid` and `rsp_result` to zero.
- R2: Field n of the register is `cr_out[31-4n:28-4n]`, and in a 64-bit word it is `word[31-4n:28-4n]` (big-endian bits 4n+32..4n+35). Mask bit n is `req_mask[7-n]`.
- R3: Op 2 copies operand field n into register field n for every n whose mask bit is set. All other fields are unchanged.
- R4: Op 1 copies the operand field into the register for the lowest-numbered field whose mask bit is set, and for that field only. With a zero mask the register is unchanged.
- R5: Op 3 returns the register field of the lowest-numbered set mask bit, in that field's position. Every other result bit is zero, including bits 63:32. A zero mask returns zero.
- R6: Op 4 writes field `req_field` with {OV, OV32, CA, CA32}, from most to least significant bit. All other fields are unchanged.
- R7: Op 5 returns the register in result bits 31:0, with bits 63:32 zero.
- R8: `rsp_valid` is `req_valid` delayed by one clock. `rsp_result` and `cr_out` reflect a request after the edge that samples it. Write and flag operations return a zero result.
- R9: With `req_valid` low, or with op 0, 3, 5, 6 or 7, the register is unchanged. Ops 0, 6 and 7 and idle cycles return a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_mask | input | 8 | Field mask, bit 7 selects field 0 |
| req_field | input | 3 | Target field for flag packing |
| req_src | input | 64 | General register operand |
| req_ov | input | 1 | Overflow flag |
| req_ov32 | input | 1 | 32-bit overflow flag |
| req_ca | input | 1 | Carry flag |
| req_ca32 | input | 1 | 32-bit carry flag |
| rsp_valid | output | 1 | Response present |
| rsp_result | output | 64 | Result word |
| cr_out | output | 32 | Current condition register |

## Verification
The assertions take for granted that every request input is a known 0 or 1 in every cycle after reset. They also take for granted that reset is held across at least one clock edge before the first request. Without these, the stability and field-position properties would be comparing unknown values. The bench drives every input to a defined value from time zero. It draws operation codes across all eight encodings, including the undefined ones, so that the no-write properties are exercised. Masks are drawn as zero, one-hot or dense, so the first-set rule sees each of its shapes.

// File: rtl/cr_xfer_pkg.sv
package cr_xfer_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_PUT_ONE  = 3'd1,
    OP_PUT_MASK = 3'd2,
    OP_GET_ONE  = 3'd3,
    OP_FLAGS    = 3'd4,
    OP_GET_ALL  = 3'd5
  } op_e;

  typedef struct packed {
    logic ov;
    logic ov32;
    logic ca;
    logic ca32;
  } xflags_t;

  // decoded operation strobes, one per defined operation
  typedef struct packed {
    logic put_one;
    logic put_mask;
    logic get_one;
    logic flags;
    logic get_all;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic valid, input logic [2:0] op);
    op_dec_t d;
    d.put_one  = valid && (op == OP_PUT_ONE);
    d.put_mask = valid && (op == OP_PUT_MASK);
    d.get_one  = valid && (op == OP_GET_ONE);
    d.flags    = valid && (op == OP_FLAGS);
    d.get_all  = valid && (op == OP_GET_ALL);
    return d;
  endfunction

endpackage

// File: rtl/cr_first_pick.sv
// Priority pick: returns, field-indexed, the lowest-numbered field whose mask
// bit is set. Mask bit for field n lives at mask[N-1-n].
module cr_first_pick #(
  parameter int unsigned NFIELDS = 8
) (
  input  logic [NFIELDS-1:0] mask,
  output logic [NFIELDS-1:0] pick,
  output logic               any
);
  logic [NFIELDS:0] seen;

  assign seen[0] = 1'b0;

  for (genvar n = 0; n < NFIELDS; n++) begin : g_chain
    assign pick[n]   = mask[NFIELDS-1-n] & ~seen[n];
    assign seen[n+1] = seen[n] | mask[NFIELDS-1-n];
  end

  assign any = seen[NFIELDS];
endmodule

// File: rtl/cr_next_state.sv
// Per-field next-state selection for the condition register.
// Field n occupies cr[CW-1-FW*n -: FW].
module cr_next_state #(
  parameter int unsigned NFIELDS = 8,
  parameter int unsigned FW      = 4,
  localparam int unsigned CW     = NFIELDS * FW
) (
  input  logic [CW-1:0]      cr,
  input  logic [CW-1:0]      src_low,
  input  logic [NFIELDS-1:0] wr_en,
  input  logic [NFIELDS-1:0] flag_en,
  input  logic [FW-1:0]      flag_nib,
  output logic [CW-1:0]      cr_nxt
);
  for (genvar n = 0; n < NFIELDS; n++) begin : g_field
    localparam int unsigned HI = CW - 1 - FW * n;
    always_comb begin
      if (flag_en[n])
        cr_nxt[HI -: FW] = flag_nib;
      else if (wr_en[n])
        cr_nxt[HI -: FW] = src_low[HI -: FW];
      else
        cr_nxt[HI -: FW] = cr[HI -: FW];
    end
  end
endmodule

// File: rtl/cr_result_gen.sv
// Result word: selected-field read, whole-register read, or zero.
module cr_result_gen #(
  parameter int unsigned NFIELDS = 8,
  parameter int unsigned FW      = 4,
  parameter int unsigned GW      = 64,
  localparam int unsigned CW     = NFIELDS * FW
) (
  input  logic               get_one,
  input  logic               get_all,
  input  logic [CW-1:0]      cr,
  input  logic [NFIELDS-1:0] pick,
  output logic [GW-1:0]      result
);
  logic [CW-1:0] field_keep;

  for (genvar n = 0; n < NFIELDS; n++) begin : g_keep
    assign field_keep[CW-1-FW*n -: FW] = {FW{pick[n]}};
  end

  always_comb begin
    result = '0;
    if (get_one)
      result[CW-1:0] = cr & field_keep;
    else if (get_all)
      result[CW-1:0] = cr;
  end
endmodule

// File: rtl/cr_field_xfer.sv
module cr_field_xfer
  import cr_xfer_pkg::*;
#(
  parameter int unsigned NFIELDS = 8,
  parameter int unsigned FW      = 4,
  parameter int unsigned GW      = 64,
  localparam int unsigned CW     = NFIELDS * FW,
  localparam int unsigned FSEL_W = (NFIELDS > 1) ? $clog2(NFIELDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_op,
  input  logic [NFIELDS-1:0] req_mask,
  input  logic [FSEL_W-1:0]  req_field,
  input  logic [GW-1:0]      req_src,
  input  logic               req_ov,
  input  logic               req_ov32,
  input  logic               req_ca,
  input  logic               req_ca32,
  output logic               rsp_valid,
  output logic [GW-1:0]      rsp_result,
  output logic [CW-1:0]      cr_out
);
  // named internal events, visible to the bound checker
  op_dec_t            dec;
  logic [NFIELDS-1:0] mask_by_field;
  logic [NFIELDS-1:0] sel_first;
  logic               pick_any;
  logic [NFIELDS-1:0] wr_en;
  logic [NFIELDS-1:0] flag_en;
  logic [FW-1:0]      flag_nib;
  logic [CW-1:0]      cr_nxt;
  logic [GW-1:0]      result_nxt;
  xflags_t            flags_in;

  assign dec = decode_op(req_valid, req_op);

  // reorder mask so that index n is field n
  for (genvar n = 0; n < NFIELDS; n++) begin : g_mask
    assign mask_by_field[n] = req_mask[NFIELDS-1-n];
  end

  cr_first_pick #(.NFIELDS(NFIELDS)) u_pick (
    .mask (req_mask),
    .pick (sel_first),
    .any  (pick_any)
  );

  always_comb begin
    wr_en = '0;
    if (dec.put_one && pick_any)
      wr_en = sel_first;
    else if (dec.put_mask)
      wr_en = mask_by_field;
  end

  for (genvar n = 0; n < NFIELDS; n++) begin : g_fdec
    assign flag_en[n] = dec.flags && (req_field == FSEL_W'(n));
  end

  assign flags_in = '{ov: req_ov, ov32: req_ov32, ca: req_ca, ca32: req_ca32};

  if (FW > 4) begin : g_nib_wide
    assign flag_nib = {flags_in, {(FW-4){1'b0}}};
  end else begin : g_nib_exact
    assign flag_nib = flags_in[3 -: FW];
  end

  cr_next_state #(.NFIELDS(NFIELDS), .FW(FW)) u_next (
    .cr       (cr_out),
    .src_low  (req_src[CW-1:0]),
    .wr_en    (wr_en),
    .flag_en  (flag_en),
    .flag_nib (flag_nib),
    .cr_nxt   (cr_nxt)
  );

  cr_result_gen #(.NFIELDS(NFIELDS), .FW(FW), .GW(GW)) u_res (
    .get_one (dec.get_one),
    .get_all (dec.get_all),
    .cr      (cr_out),
    .pick    (sel_first),
    .result  (result_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_out     <= '0;
      rsp_valid  <= 1'b0;
      rsp_result <= '0;
    end else begin
      cr_out     <= cr_nxt;
      rsp_valid  <= req_valid;
      rsp_result <= result_nxt;
    end
  end
endmodule

// File: rtl/cr_field_xfer_chk.sv
module cr_field_xfer_chk
  import cr_xfer_pkg::*;
#(
  parameter int unsigned NFIELDS = 8,
  parameter int unsigned FW      = 4,
  parameter int unsigned GW      = 64,
  localparam int unsigned CW     = NFIELDS * FW,
  localparam int unsigned FSEL_W = (NFIELDS > 1) ? $clog2(NFIELDS) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [2:0]         req_op,
  input logic [NFIELDS-1:0] req_mask,
  input logic [FSEL_W-1:0]  req_field,
  input logic               req_ov,
  input logic               req_ov32,
  input logic               req_ca,
  input logic               req_ca32,
  input logic               rsp_valid,
  input logic [GW-1:0]      rsp_result,
  input logic [CW-1:0]      cr_out,
  input logic [NFIELDS-1:0] sel_first,
  input logic [NFIELDS-1:0] wr_en
);
  logic [FSEL_W-1:0] fld_q;
  logic [FW-1:0]     got_nib;

  always_ff @(posedge clk) begin
    if (rst) fld_q <= '0;
    else     fld_q <= req_field;
  end

  always_comb got_nib = FW'(cr_out >> (CW - FW - FW * int'(fld_q)));

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cr_out == '0 && !rsp_valid && rsp_result == '0));

  a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r8_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r4_pick_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_first));

  a_r4_write_one_single: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_PUT_ONE) |-> $countones(wr_en) == $countones(req_mask != '0));

  a_r5_get_one_upper: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_GET_ONE) |=> rsp_result[GW-1:CW] == '0);

  a_r5_zero_mask: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_GET_ONE && req_mask == '0) |=> rsp_result == '0);

  a_r6_flag_field: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_FLAGS) |=>
      got_nib[FW-1 -: 4] == $past({req_ov, req_ov32, req_ca, req_ca32}));

  a_r7_get_all: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_GET_ALL) |=> rsp_result == {{(GW-CW){1'b0}}, $past(cr_out)});

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_op == OP_IDLE || req_op == OP_GET_ONE ||
     req_op == OP_GET_ALL || req_op > OP_GET_ALL) |=> $stable(cr_out));

  for (genvar n = 0; n < NFIELDS; n++) begin : g_keep
    a_r3_unselected_keep: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_op == OP_PUT_MASK && !req_mask[NFIELDS-1-n]) |=>
        $stable(cr_out[CW-1-FW*n -: FW]));
  end
endmodule

bind cr_field_xfer cr_field_xfer_chk #(.NFIELDS(NFIELDS), .FW(FW), .GW(GW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_mask   (req_mask),
  .req_field  (req_field),
  .req_ov     (req_ov),
  .req_ov32   (req_ov32),
  .req_ca     (req_ca),
  .req_ca32   (req_ca32),
  .rsp_valid  (rsp_valid),
  .rsp_result (rsp_result),
  .cr_out     (cr_out),
  .sel_first  (sel_first),
  .wr_en      (wr_en)
);

// File: tb/sim_cr_field_xfer.sv
`timescale 1ns/1ps
module sim_cr_field_xfer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_mask = '0;
  logic [2:0]  req_field = '0;
  logic [63:0] req_src = '0;
  logic        req_ov = 1'b0, req_ov32 = 1'b0, req_ca = 1'b0, req_ca32 = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_result;
  logic [31:0] cr_out;

  int checks = 0;
  int errors = 0;
  logic [63:0] model = '0;   // big-endian model word, upper half always zero

  always #2 clk = ~clk;      // 4 ns period

  cr_field_xfer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_mask(req_mask), .req_field(req_field), .req_src(req_src),
    .req_ov(req_ov), .req_ov32(req_ov32), .req_ca(req_ca), .req_ca32(req_ca32),
    .rsp_valid(rsp_valid), .rsp_result(rsp_result), .cr_out(cr_out)
  );

  // field n taken bit by bit in big-endian order: positions 4n+32 .. 4n+35
  function automatic logic [3:0] be_get(input logic [63:0] w, input int n);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[3-k] = w[63-(4*n+32+k)];
    return r;
  endfunction

  function automatic logic [63:0] be_put(input logic [63:0] w, input int n, input logic [3:0] v);
    logic [63:0] r = w;
    for (int k = 0; k < 4; k++) r[63-(4*n+32+k)] = v[3-k];
    return r;
  endfunction

  function automatic int first_set(input logic [7:0] m);
    for (int n = 0; n < 8; n++) if (m[7-n]) return n;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; checks at the next falling edge
  task automatic issue(input logic v, input logic [2:0] op, input logic [7:0] m,
                       input logic [2:0] f, input logic [63:0] s, input logic [3:0] fl);
    logic [63:0] res = '0;
    int          n;
    string       tag;
    req_valid = v; req_op = op; req_mask = m; req_field = f; req_src = s;
    {req_ov, req_ov32, req_ca, req_ca32} = fl;
    tag = "R9";
    if (v) begin
      case (op)
        3'd1: begin tag = "R4"; n = first_set(m);
                if (n >= 0) model = be_put(model, n, be_get(s, n)); end
        3'd2: begin tag = "R3";
                for (int j = 0; j < 8; j++) if (m[7-j]) model = be_put(model, j, be_get(s, j)); end
        3'd3: begin tag = "R5"; n = first_set(m);
                if (n >= 0) res = be_put(64'd0, n, be_get(model, n)); end
        3'd4: begin tag = "R6"; model = be_put(model, int'(f), fl); end
        3'd5: begin tag = "R7"; res = model; end
        default: tag = "R9";
      endcase
    end
    @(negedge clk);
    check({tag, " register"}, {32'd0, cr_out}, model);
    check({tag, " result"}, rsp_result, res);
    check("R8 valid", {63'd0, rsp_valid}, {63'd0, v});
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    model = '0;
    check("R1 register", {32'd0, cr_out}, 64'd0);
    check("R1 result", rsp_result, 64'd0);
    check("R1 valid", {63'd0, rsp_valid}, 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] m;
    void'($urandom(32'h1F2E3D4C));
    @(negedge clk);
    do_reset();

    // R2: field 0 is the top nibble, mask bit 7 selects it
    issue(1'b1, 3'd2, 8'h80, 3'd0, 64'hFFFF_FFFF_A000_0000, 4'h0);
    check("R2 field0 position", {32'd0, cr_out}, 64'h0000_0000_A000_0000);
    // R3: all fields
    issue(1'b1, 3'd2, 8'hFF, 3'd0, 64'hDEAD_BEEF_1234_5678, 4'h0);
    // R3: sparse mask
    issue(1'b1, 3'd2, 8'h5A, 3'd0, 64'h0000_0000_9ABC_DEF0, 4'h0);
    // R4: several bits set, only the first (field 2) changes
    issue(1'b1, 3'd1, 8'h25, 3'd0, 64'h0000_0000_0000_0000, 4'h0);
    // R4: zero mask leaves register unchanged
    issue(1'b1, 3'd1, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
    // R5: first-set rule and zero mask
    issue(1'b1, 3'd3, 8'h24, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
    issue(1'b1, 3'd3, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
    issue(1'b1, 3'd3, 8'h01, 3'd0, 64'h0, 4'h0);
    // R6: flag ordering into both end fields
    issue(1'b1, 3'd4, 8'h00, 3'd0, 64'h0, 4'b1000);
    issue(1'b1, 3'd4, 8'h00, 3'd7, 64'h0, 4'b0001);
    issue(1'b1, 3'd4, 8'h00, 3'd3, 64'h0, 4'b0110);
    // R7: whole register
    issue(1'b1, 3'd5, 8'h00, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0);
    // R9: undefined code, idle code, and no valid
    issue(1'b1, 3'd6, 8'hFF, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF);
    issue(1'b1, 3'd7, 8'hFF, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF);
    issue(1'b1, 3'd0, 8'hFF, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF);
    issue(1'b0, 3'd2, 8'hFF, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 4'hF);
    issue(1'b1, 3'd5, 8'h00, 3'd0, 64'h0, 4'h0);

    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 3))
        0: m = 8'h00;
        1: m = 8'h01 << $urandom_range(0, 7);
        default: m = 8'($urandom());
      endcase
      issue($urandom_range(0, 9) != 0, 3'($urandom_range(0, 7)), m,
            3'($urandom_range(0, 7)), {$urandom(), $urandom()}, 4'($urandom()));
    end

    do_reset();
    issue(1'b1, 3'd5, 8'h00, 3'd0, 64'h0, 4'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule